// File: doc/BRIEF.md
# Dual-Threshold Supply Monitor Filter

This block is the digital back end for ten supply-monitor channels. Every channel delivers two raw comparator levels from analog circuitry outside the block. Comparator A trips at an upper threshold and comparator B trips at a lower threshold. Each raw level is first brought into the master clock domain with two flops. It then passes through a glitch filter, and the filter delay is chosen per channel as either a short setting or a long setting. The short setting is 16 µs and the long setting is 64 µs, both counted in master-clock cycles.

After filtering, a channel can report its two comparators separately, acting as a high/low monitor. It can instead report an in-bounds result, acting as a window comparison. The filtered results of all channels are registered into a 24-bit status word. The word is meant to be read as three bytes by a register interface.

Top module: `supmon_filter_top`

## Requirements
- R1: While `rst_i` is high on a rising edge, the status word clears to zero on that edge, and all filter outputs clear to zero as well.
- R2: When a channel's `long_en_i` bit is 0, a raw level that changes just before rising edge E0 and then holds appears in the status word on edge E0+SHORT_CNT+2. Here SHORT_CNT is 16 µs of master clock, which is 128 cycles by default. On the edge before that, the status word still holds the old value.
- R3: When a channel's `long_en_i` bit is 1, the same timing applies with LONG_CNT in place of SHORT_CNT. LONG_CNT is 64 µs of master clock, which is 512 cycles by default.
- R4: A change whose synchronized level lasts fewer than the selected delay count leaves the status word unchanged. The delay counter restarts whenever the synchronized level equals the current filtered output, so a change that breaks up before the full count is timed again from zero.
- R5: Channel k, counted from 0, places its A-position bit at status bit 23-2k and its B-position bit at status bit 22-2k. Status bits [23:16], [15:8] and [7:0] form bytes 0, 1 and 2.
- R6: When a channel's `win_en_i` bit is 1, its A-position bit reports the in-bounds result, which is (filtered B AND NOT filtered A), and its B-position bit reports filtered B. When the bit is 0, the A-position bit reports filtered A and the B-position bit reports filtered B.
- R7: Each channel is filtered on its own: a change on one channel, or on one comparator of a channel, never alters another channel's status bits.
- R8: Status bits [3:0] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| raw_a_i | input | 10 | Raw upper-threshold comparator level per channel (1 = above) |
| raw_b_i | input | 10 | Raw lower-threshold comparator level per channel (1 = above) |
| long_en_i | input | 10 | Per-channel filter delay select: 1 = long, 0 = short |
| win_en_i | input | 10 | Per-channel window-compare enable |
| status_o | output | 24 | Packed filtered status, byte 0 in [23:16] |

## Verification
The assertions assume that `long_en_i` and `win_en_i` are configuration values that stay constant outside reset. The counter-bound check and the in-bounds implication rely on this, because a delay select that changes in the middle of a count could leave the counter above the new limit. The bench therefore sets both vectors before reset is released and never changes them. The bench drives only the raw comparator levels, and it holds each level for a known number of cycles so that every expected change lands on a predictable edge.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    parameter int unsigned NUM_CH_DEF   = 10;
    parameter int unsigned CLK_PER_US   = 8;
    parameter int unsigned SHORT_US     = 16;
    parameter int unsigned LONG_US      = 64;

    // One filtered comparator pair of a channel
    typedef struct packed {
        logic upper;
        logic lower;
    } cmp_pair_t;

    // Bits reported for one channel, in A/B slot order
    function automatic logic [1:0] report_bits(input cmp_pair_t p, input logic window);
        logic in_bounds;
        in_bounds = p.lower & ~p.upper;
        return {(window ? in_bounds : p.upper), p.lower};
    endfunction

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/supmon_glitch_filter.sv
module supmon_glitch_filter #(
    parameter int unsigned SHORT_CNT = 128,
    parameter int unsigned LONG_CNT  = 512
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic long_i,
    input  logic din_i,
    output logic dout_o
);
    localparam int unsigned CW = $clog2(LONG_CNT + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          out_q;

    assign limit = long_i ? CW'(LONG_CNT - 1) : CW'(SHORT_CNT - 1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= 1'b0;
            cnt_q <= '0;
        end else if (din_i == out_q) begin
            cnt_q <= '0;
        end else if (cnt_q == limit) begin
            out_q <= din_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout_o = out_q;

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= limit); // R3

    AST_HOLD_UNTIL_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(dout_o) |-> ($past(cnt_q) == $past(limit))); // R4

    AST_TAKE_AT_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
        (din_i != dout_o && cnt_q == limit) |=> (dout_o == $past(din_i))); // R2

endmodule

// File: rtl/supmon_filter_top.sv
module supmon_filter_top
    import supmon_pkg::*;
#(
    parameter int unsigned NUM_CH     = NUM_CH_DEF,
    parameter int unsigned CLK_PER_US_P = CLK_PER_US,
    parameter int unsigned SHORT_US_P = SHORT_US,
    parameter int unsigned LONG_US_P  = LONG_US
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_CH-1:0]   raw_a_i,
    input  logic [NUM_CH-1:0]   raw_b_i,
    input  logic [NUM_CH-1:0]   long_en_i,
    input  logic [NUM_CH-1:0]   win_en_i,
    output logic [23:0]         status_o
);
    localparam int unsigned SHORT_CNT    = SHORT_US_P * CLK_PER_US_P;
    localparam int unsigned LONG_CNT     = LONG_US_P * CLK_PER_US_P;
    localparam int unsigned STATUS_BYTES = (2 * NUM_CH + 7) / 8;
    localparam int unsigned STATUS_W     = 8 * STATUS_BYTES;

    logic [2*NUM_CH-1:0] raw_bits, sync_bits, filt_bits;
    cmp_pair_t [NUM_CH-1:0] filt_pair;
    logic [STATUS_W-1:0] status_d, status_q;

    // Interleave: bit 2k = upper (A), bit 2k+1 = lower (B)
    for (genvar k = 0; k < NUM_CH; k++) begin : g_pack_raw
        assign raw_bits[2*k]   = raw_a_i[k];
        assign raw_bits[2*k+1] = raw_b_i[k];
    end

    supmon_sync #(.WIDTH(2 * NUM_CH)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_bits),
        .q_o   (sync_bits)
    );

    for (genvar j = 0; j < 2 * NUM_CH; j++) begin : g_filter
        supmon_glitch_filter #(
            .SHORT_CNT (SHORT_CNT),
            .LONG_CNT  (LONG_CNT)
        ) u_filt (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .long_i (long_en_i[j/2]),
            .din_i  (sync_bits[j]),
            .dout_o (filt_bits[j])
        );
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_pair
        assign filt_pair[k].upper = filt_bits[2*k];
        assign filt_pair[k].lower = filt_bits[2*k+1];
    end

    always_comb begin
        status_d = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            status_d[STATUS_W-1-2*k -: 2] = report_bits(filt_pair[k], win_en_i[k]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) status_q <= '0;
        else       status_q <= status_d;
    end

    assign status_o = 24'(status_q);

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        $past(rst_i) |-> (status_o == '0)); // R1

    AST_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        status_o[3:0] == 4'h0); // R8

    for (genvar k = 0; k < NUM_CH; k++) begin : g_win_chk
        AST_INBOUNDS_NEEDS_LOWER: assert property (@(posedge clk_i) disable iff (rst_i)
            (win_en_i[k] && status_o[23-2*k]) |-> status_o[22-2*k]); // R6
    end

endmodule

// File: tb/supmon_filter_top_bench.sv
module supmon_filter_top_bench;

    localparam int N = 10;
    localparam int S = 128;
    localparam int L = 512;

    typedef struct {
        int          at;
        logic [23:0] exp;
        string       req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] raw_a = '0, raw_b = '0;
    logic [N-1:0] long_en, win_en;
    logic [23:0] status;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;
    sb_item_t sb[$];

    // Bench model of settled filtered levels
    logic [N-1:0] m_a = '0, m_b = '0;

    supmon_filter_top u_supmon_filter_top (
        .clk_i     (clk),
        .rst_i     (rst),
        .raw_a_i   (raw_a),
        .raw_b_i   (raw_b),
        .long_en_i (long_en),
        .win_en_i  (win_en),
        .status_o  (status)
    );

    always #10ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [23:0] model_status();
        logic [23:0] v = '0;
        for (int k = 0; k < N; k++) begin
            v[23-2*k] = win_en[k] ? (m_b[k] & ~m_a[k]) : m_a[k];
            v[22-2*k] = m_b[k];
        end
        return v;
    endfunction

    task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic push(input int at, input string req);
        sb_item_t it;
        it.at = at; it.exp = model_status(); it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: compare items when their cycle arrives
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            if (sb[0].at < cyc) begin
                checks++; fails++;
                $display("FAIL %s missed slot actual=%h expected=%h", sb[0].req, status, sb[0].exp);
            end else begin
                check(status, sb[0].exp, sb[0].req);
            end
            void'(sb.pop_front());
        end
    end

    task automatic settle();
        while (sb.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Drive a new level on one channel; queue old/new expectations around the edge
    task automatic step(input int ch, input logic a, input logic b, input string req);
        int dly;
        dly = long_en[ch] ? L : S;
        push(cyc + dly + 2, req);
        raw_a[ch] = a; raw_b[ch] = b;
        m_a[ch] = a; m_b[ch] = b;
        push(cyc + dly + 3, req);
    endtask

    initial begin
        long_en = '0; long_en[3] = 1'b1; long_en[2] = 1'b1;
        win_en  = '0; win_en[7] = 1'b1;
        repeat (5) @(negedge clk);
        check(status, 24'h0, "R1");
        rst = 1'b0;
        @(negedge clk);

        // R2, R5: channel 0 upper, short delay
        step(0, 1'b1, 1'b0, "R2"); settle();
        // R3: channel 3 lower, long delay
        step(3, 1'b0, 1'b1, "R3"); settle();

        // R4: glitch shorter than the delay
        raw_a[5] = 1'b1;
        repeat (S - 2) @(negedge clk);
        raw_a[5] = 1'b0;
        push(cyc + S + 4, "R4");
        push(cyc + S + 20, "R4");
        settle();
        // R4: restart after a one-cycle dropout
        raw_a[5] = 1'b1;
        repeat (S - 1) @(negedge clk);
        raw_a[5] = 1'b0;
        @(negedge clk);
        step(5, 1'b1, 1'b0, "R4"); settle();

        // R5, R8: channel 9 both bits in byte 2, spare nibble
        step(9, 1'b1, 1'b1, "R5"); settle();
        check(status & 24'h00000F, 24'h0, "R8");

        // R6: window channel 7, in bounds then above upper
        step(7, 1'b0, 1'b1, "R6"); settle();
        step(7, 1'b1, 1'b1, "R6"); settle();
        step(7, 1'b0, 1'b0, "R6"); settle();

        // R7: channels 1 (short) and 2 (long) in the same cycle
        raw_a[1] = 1'b1; raw_a[2] = 1'b1;
        push(cyc + S + 2, "R7");
        m_a[1] = 1'b1;
        push(cyc + S + 3, "R7");
        push(cyc + L + 2, "R7");
        m_a[2] = 1'b1;
        push(cyc + L + 3, "R7");
        settle();

        // R2: falling change on channel 0
        step(0, 1'b0, 1'b0, "R2"); settle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule